// File: doc/BRIEF.md
# Integer ALU with Status Flags

This block is the arithmetic and logic stage of a small 16-bit processor datapath. It receives a destination operand, a source operand, a 4-bit operation code and a byte/word size select. It returns the operation result in the same cycle, together with strobes that say which result words the register file should write back. It also holds six status flags: carry, parity, auxiliary (nibble) carry, zero, sign and overflow. The flags are kept in a register inside the block. The stored carry is the carry input for add-with-carry and subtract-with-borrow.

The flag register loads on a rising clock edge while `op_valid_i` is high. Each operation changes only the flags it defines and leaves the rest at their stored values. Increment and decrement keep the carry. Inversion and the two sign-extension operations keep every flag. Compare and test compute their value and update the flags but request no write-back. Multiply, divide, decimal adjust, operand fetch and addressing belong to other blocks.

Top module: `alu_flags_unit`

## Requirements
- R1: Operation codes are 0 add, 1 add-with-carry, 2 subtract, 3 subtract-with-borrow, 4 compare, 5 increment, 6 decrement, 7 negate, 8 AND, 9 OR, 10 XOR, 11 NOT, 12 test, 13 byte-to-word extension, 14 word-to-double extension, 15 reserved. Add gives dst+src, and add-with-carry gives dst+src+CF. Both set CF to the carry out of the operand width and update all six flags.
- R2: Subtract gives dst-src, subtract-with-borrow gives dst-src-CF, and compare computes dst-src. All three set CF to the borrow and OF when the operand signs differ and the result sign differs from the destination sign. All three update all six flags.
- R3: Increment gives dst+1 and decrement gives dst-1. Both update AF, OF, PF, SF and ZF and leave CF at its stored value.
- R4: Negate gives 0-dst in two's complement. CF is set for any non-zero operand, and all six flags update.
- R5: AND, OR and XOR write the bitwise result, update PF, SF and ZF, force CF and OF to 0 and keep AF. Test does the same as AND. NOT writes the bitwise inverse of dst.
- R6: NOT, both sign extensions and the reserved code leave all six flags unchanged.
- R7: `wr_en_o` is high for codes 0-3, 5-11 and 13, and low for compare, test, word-to-double extension and the reserved code. `result_o` still shows the computed value for compare and test, and equals dst for codes 14 and 15.
- R8: With `word_i` low, arithmetic and logic operations work on bit 7..0. CF, OF, SF (bit 7) and ZF come from the 8-bit result, and `result_o[15:8]` equals `dst_i[15:8]`. With `word_i` high they use the full 16 bits, with SF taken from bit 15.
- R9: PF is 1 when `result_o[7:0]` holds an even number of ones. AF is the carry (add types) or borrow (subtract types) out of bit 3.
- R10: Byte-to-word extension writes bit 7 of dst into bits 15..8 of the result, whatever `word_i` is. `result_hi_o` always carries 16 copies of dst bit 15 and is written (`wr_hi_en_o`) only for word-to-double extension.
- R11: `flags_o` is bit 0 CF, bit 1 PF, bit 2 AF, bit 3 ZF, bit 4 SF, bit 5 OF. A synchronous reset clears it to 0. New flags appear after the clock edge on which `op_valid_i` is high. With `op_valid_i` low the flags hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid_i | input | 1 | Operation present, loads the flag register |
| op_code_i | input | 4 | Operation code |
| word_i | input | 1 | 1 = 16-bit operation, 0 = 8-bit operation |
| dst_i | input | 16 | Destination operand |
| src_i | input | 16 | Source operand |
| result_o | output | 16 | Combinational result |
| result_hi_o | output | 16 | Sign-fill high word |
| wr_en_o | output | 1 | Write back result_o |
| wr_hi_en_o | output | 1 | Write back result_hi_o |
| flags_o | output | 6 | Registered status flags |

## Verification
Two functions can land in one cycle. A carry-consuming operation (add-with-carry, subtract-with-borrow, increment, decrement) reads the stored carry while the flag register loads the value that operation produces. Back-to-back sweeps of every operation run without idle cycles, so each operation reads the carry left by the previous one, including a carry that increment or decrement carried through. The bench keeps its own flag model, updated one operation at a time from arithmetic on integers, and compares the result in mid-cycle and the flags after each edge.

// File: rtl/alu_pkg.sv
package alu_pkg;

    typedef enum logic [3:0] {
        OP_ADD  = 4'd0,
        OP_ADC  = 4'd1,
        OP_SUB  = 4'd2,
        OP_SBB  = 4'd3,
        OP_CMP  = 4'd4,
        OP_INC  = 4'd5,
        OP_DEC  = 4'd6,
        OP_NEG  = 4'd7,
        OP_AND  = 4'd8,
        OP_OR   = 4'd9,
        OP_XOR  = 4'd10,
        OP_NOT  = 4'd11,
        OP_TEST = 4'd12,
        OP_EXTB = 4'd13,
        OP_EXTW = 4'd14,
        OP_RSVD = 4'd15
    } alu_op_e;

    // bit 5..0 : of, sf, zf, af, pf, cf
    typedef struct packed {
        logic of;
        logic sf;
        logic zf;
        logic af;
        logic pf;
        logic cf;
    } alu_flags_t;

    localparam alu_flags_t UPD_ALL   = 6'b111111;
    localparam alu_flags_t UPD_NOCF  = 6'b111110;
    localparam alu_flags_t UPD_LOGIC = 6'b111011;
    localparam alu_flags_t UPD_NONE  = 6'b000000;

    function automatic logic even_ones(input logic [7:0] v);
        return ~^v;
    endfunction

endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
    parameter int DATA_W = 16,
    parameter int NIB_W  = 4
) (
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    input  logic              cin_i,
    input  logic              sub_i,
    input  logic              word_i,
    output logic [DATA_W-1:0] sum_o,
    output logic              carry_o,
    output logic              aux_o,
    output logic              ovf_o
);
    localparam int HALF_W = DATA_W / 2;

    logic [DATA_W-1:0] bx;
    logic              ci;
    logic [DATA_W:0]   full;
    logic [HALF_W:0]   low;
    logic [NIB_W:0]    nib;
    logic              sa, sb, sr;

    always_comb begin
        bx    = b_i ^ {DATA_W{sub_i}};
        ci    = cin_i ^ sub_i;
        full  = {1'b0, a_i} + {1'b0, bx} + {{DATA_W{1'b0}}, ci};
        low   = {1'b0, a_i[HALF_W-1:0]} + {1'b0, bx[HALF_W-1:0]} + {{HALF_W{1'b0}}, ci};
        nib   = {1'b0, a_i[NIB_W-1:0]} + {1'b0, bx[NIB_W-1:0]} + {{NIB_W{1'b0}}, ci};
        sum_o = full[DATA_W-1:0];
        // carry out converts to borrow for subtraction
        carry_o = (word_i ? full[DATA_W] : low[HALF_W]) ^ sub_i;
        aux_o   = nib[NIB_W] ^ sub_i;
        sa = word_i ? a_i[DATA_W-1]  : a_i[HALF_W-1];
        sb = word_i ? bx[DATA_W-1]   : bx[HALF_W-1];
        sr = word_i ? full[DATA_W-1] : low[HALF_W-1];
        ovf_o = (sa == sb) && (sr != sa);
    end

endmodule

// File: rtl/alu_logic.sv
module alu_logic
    import alu_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  alu_op_e           op_i,
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    output logic [DATA_W-1:0] res_o
);
    always_comb begin
        unique case (op_i)
            OP_OR:   res_o = a_i | b_i;
            OP_XOR:  res_o = a_i ^ b_i;
            OP_NOT:  res_o = ~a_i;
            default: res_o = a_i & b_i;
        endcase
    end

endmodule

// File: rtl/alu_flag_reg.sv
module alu_flag_reg
    import alu_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       load_i,
    input  alu_flags_t mask_i,
    input  alu_flags_t next_i,
    output alu_flags_t flags_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            flags_o <= '0;
        end else if (load_i) begin
            flags_o <= (flags_o & ~mask_i) | (next_i & mask_i);
        end
    end

endmodule

// File: rtl/alu_flags_unit.sv
module alu_flags_unit
    import alu_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              op_valid_i,
    input  logic [3:0]        op_code_i,
    input  logic              word_i,
    input  logic [DATA_W-1:0] dst_i,
    input  logic [DATA_W-1:0] src_i,
    output logic [DATA_W-1:0] result_o,
    output logic [DATA_W-1:0] result_hi_o,
    output logic              wr_en_o,
    output logic              wr_hi_en_o,
    output logic [5:0]        flags_o
);
    localparam int HALF_W = DATA_W / 2;

    alu_op_e           op;
    alu_flags_t        cur_flags, next_flags, upd_mask;
    logic [DATA_W-1:0] a_in, b_in, sum, lres, core;
    logic              cin, sub, is_arith, is_logic;
    logic              carry, aux, ovf;

    assign op = alu_op_e'(op_code_i);

    always_comb begin
        a_in = dst_i;  b_in = src_i;  cin = 1'b0;  sub = 1'b0;
        is_arith = 1'b0;  is_logic = 1'b0;
        wr_en_o = 1'b0;  wr_hi_en_o = 1'b0;
        upd_mask = UPD_NONE;
        unique case (op)
            OP_ADD:  begin is_arith = 1'b1; wr_en_o = 1'b1; upd_mask = UPD_ALL; end
            OP_ADC:  begin is_arith = 1'b1; wr_en_o = 1'b1; upd_mask = UPD_ALL; cin = cur_flags.cf; end
            OP_SUB:  begin is_arith = 1'b1; wr_en_o = 1'b1; upd_mask = UPD_ALL; sub = 1'b1; end
            OP_SBB:  begin is_arith = 1'b1; wr_en_o = 1'b1; upd_mask = UPD_ALL; sub = 1'b1; cin = cur_flags.cf; end
            OP_CMP:  begin is_arith = 1'b1; upd_mask = UPD_ALL; sub = 1'b1; end
            OP_INC:  begin is_arith = 1'b1; wr_en_o = 1'b1; upd_mask = UPD_NOCF; b_in = DATA_W'(1); end
            OP_DEC:  begin is_arith = 1'b1; wr_en_o = 1'b1; upd_mask = UPD_NOCF; b_in = DATA_W'(1); sub = 1'b1; end
            OP_NEG:  begin is_arith = 1'b1; wr_en_o = 1'b1; upd_mask = UPD_ALL; a_in = '0; b_in = dst_i; sub = 1'b1; end
            OP_AND, OP_OR, OP_XOR:
                     begin is_logic = 1'b1; wr_en_o = 1'b1; upd_mask = UPD_LOGIC; end
            OP_TEST: begin is_logic = 1'b1; upd_mask = UPD_LOGIC; end
            OP_NOT:  begin is_logic = 1'b1; wr_en_o = 1'b1; end
            OP_EXTB: wr_en_o = 1'b1;
            OP_EXTW: wr_hi_en_o = 1'b1;
            default: ;
        endcase
    end

    alu_addsub #(.DATA_W(DATA_W), .NIB_W(4)) addsub_i (
        .a_i(a_in), .b_i(b_in), .cin_i(cin), .sub_i(sub), .word_i(word_i),
        .sum_o(sum), .carry_o(carry), .aux_o(aux), .ovf_o(ovf)
    );

    alu_logic #(.DATA_W(DATA_W)) logic_i (
        .op_i(op), .a_i(dst_i), .b_i(src_i), .res_o(lres)
    );

    always_comb begin
        core = is_arith ? sum : lres;
        if (is_arith || is_logic) begin
            result_o = word_i ? core : {dst_i[DATA_W-1:HALF_W], core[HALF_W-1:0]};
        end else if (op == OP_EXTB) begin
            result_o = {{HALF_W{dst_i[HALF_W-1]}}, dst_i[HALF_W-1:0]};
        end else begin
            result_o = dst_i;
        end
        result_hi_o = {DATA_W{dst_i[DATA_W-1]}};

        next_flags.cf = is_arith & carry;
        next_flags.of = is_arith & ovf;
        next_flags.af = aux;
        next_flags.pf = even_ones(result_o[7:0]);
        next_flags.sf = word_i ? result_o[DATA_W-1] : result_o[HALF_W-1];
        next_flags.zf = word_i ? (result_o == '0) : (result_o[HALF_W-1:0] == '0);
    end

    alu_flag_reg flag_reg_i (
        .clk(clk), .rst(rst), .load_i(op_valid_i),
        .mask_i(upd_mask), .next_i(next_flags), .flags_o(cur_flags)
    );

    assign flags_o = cur_flags;

    // R3: carry survives increment and decrement
    a_r3_cf_kept: assert property (@(posedge clk) disable iff (rst)
        op_valid_i && (op == OP_INC || op == OP_DEC) |=> flags_o[0] == $past(flags_o[0]));

    // R5: logic ops clear carry and overflow
    a_r5_logic_clear: assert property (@(posedge clk) disable iff (rst)
        op_valid_i && (op == OP_AND || op == OP_OR || op == OP_XOR || op == OP_TEST)
        |=> (flags_o[0] == 1'b0) && (flags_o[5] == 1'b0));

    // R6: flag-neutral operations
    a_r6_flags_frozen: assert property (@(posedge clk) disable iff (rst)
        op_valid_i && (op == OP_NOT || op == OP_EXTB || op == OP_EXTW || op == OP_RSVD)
        |=> $stable(flags_o));

    // R7: compare and test write nothing back
    a_r7_no_writeback: assert property (@(posedge clk) disable iff (rst)
        (op == OP_CMP || op == OP_TEST) |-> !wr_en_o && !wr_hi_en_o);

    // R10: only one write strobe at a time
    a_r10_one_strobe: assert property (@(posedge clk) disable iff (rst)
        1'b1 |-> $countones({wr_en_o, wr_hi_en_o}) <= 1);

    // R11: idle cycles hold the flags
    a_r11_idle_hold: assert property (@(posedge clk) disable iff (rst)
        !op_valid_i |=> $stable(flags_o));

    // R8: zero flag follows the width-selected result of an arithmetic op
    a_r8_zero_width: assert property (@(posedge clk) disable iff (rst)
        op_valid_i && is_arith |=>
        flags_o[3] == ($past(word_i) ? ($past(result_o) == '0)
                                     : ($past(result_o[HALF_W-1:0]) == '0)));

endmodule

// File: tb/alu_flags_unit_tb_top.sv
module alu_flags_unit_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        op_valid_i = 1'b0;
    logic [3:0]  op_code_i = '0;
    logic        word_i = 1'b0;
    logic [15:0] dst_i = '0, src_i = '0;
    logic [15:0] result_o, result_hi_o;
    logic        wr_en_o, wr_hi_en_o;
    logic [5:0]  flags_o;

    int n_checks = 0;
    int n_fail   = 0;
    logic [5:0]  mflags = '0;
    logic [31:0] seed = 32'h1234_5678;

    always #(CLK_PERIOD/2) clk = ~clk;

    alu_flags_unit dut_i (
        .clk(clk), .rst(rst), .op_valid_i(op_valid_i), .op_code_i(op_code_i),
        .word_i(word_i), .dst_i(dst_i), .src_i(src_i),
        .result_o(result_o), .result_hi_o(result_hi_o),
        .wr_en_o(wr_en_o), .wr_hi_en_o(wr_hi_en_o), .flags_o(flags_o)
    );

    function automatic string req_of(input int op);
        case (op)
            0, 1:        return "R1";
            2, 3, 4:     return "R2";
            5, 6:        return "R3";
            7:           return "R4";
            8, 9, 10, 12: return "R5";
            11, 15:      return "R6";
            default:     return "R10";
        endcase
    endfunction

    task automatic check(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // independent reference model of one operation
    task automatic model(input int op, input bit w, input logic [15:0] d, input logic [15:0] s,
                         input logic [5:0] fi, output logic [15:0] r, output bit wr,
                         output bit hw, output logic [5:0] fo);
        int nb, m, x, y, ci, rr, kind;
        bit isub, ar, lg, cf, af, of, sx, sy, sr, pf, zf, sf;
        nb = w ? 16 : 8;
        m  = (1 << nb) - 1;
        x = int'(d) & m;  y = int'(s) & m;  ci = 0;
        isub = 0; ar = 0; lg = 0; kind = 0; rr = 0;
        wr = 0; hw = 0; r = d; fo = fi;
        cf = 0; af = 0; of = 0;
        case (op)
            0:  begin ar = 1; kind = 1; wr = 1; end
            1:  begin ar = 1; kind = 1; wr = 1; ci = int'(fi[0]); end
            2:  begin ar = 1; kind = 1; wr = 1; isub = 1; end
            3:  begin ar = 1; kind = 1; wr = 1; isub = 1; ci = int'(fi[0]); end
            4:  begin ar = 1; kind = 1; isub = 1; end
            5:  begin ar = 1; kind = 2; wr = 1; y = 1; end
            6:  begin ar = 1; kind = 2; wr = 1; y = 1; isub = 1; end
            7:  begin ar = 1; kind = 1; wr = 1; y = x; x = 0; isub = 1; end
            8:  begin lg = 1; kind = 3; wr = 1; rr = x & y; end
            9:  begin lg = 1; kind = 3; wr = 1; rr = x | y; end
            10: begin lg = 1; kind = 3; wr = 1; rr = x ^ y; end
            11: begin lg = 1; wr = 1; rr = ~x & m; end
            12: begin lg = 1; kind = 3; rr = x & y; end
            13: begin wr = 1; r = {{8{d[7]}}, d[7:0]}; end
            14: hw = 1;
            default: ;
        endcase
        if (ar) begin
            if (!isub) begin
                rr = x + y + ci;
                cf = ((rr >> nb) & 1) != 0;
                af = ((x & 15) + (y & 15) + ci) > 15;
            end else begin
                rr = x - y - ci;
                cf = x < (y + ci);
                af = (x & 15) < ((y & 15) + ci);
            end
            rr = rr & m;
            sx = ((x >> (nb-1)) & 1) != 0;
            sy = ((y >> (nb-1)) & 1) != 0;
            sr = ((rr >> (nb-1)) & 1) != 0;
            of = isub ? (sx != sy && sr != sx) : (sx == sy && sr != sx);
        end
        if (ar || lg) begin
            r  = w ? 16'(rr) : {d[15:8], 8'(rr)};
            pf = ($countones(rr & 255) % 2) == 0;
            zf = rr == 0;
            sf = ((rr >> (nb-1)) & 1) != 0;
            case (kind)
                1: fo = {of, sf, zf, af, pf, cf};
                2: fo = {of, sf, zf, af, pf, fi[0]};
                3: fo = {1'b0, sf, zf, fi[2], pf, 1'b0};
                default: ;
            endcase
        end
    endtask

    task automatic run_op(input int op, input bit w, input logic [15:0] d, input logic [15:0] s);
        logic [15:0] er;
        logic [5:0]  ef;
        bit ewr, ehw;
        string rq;
        model(op, w, d, s, mflags, er, ewr, ehw, ef);
        rq = req_of(op);
        @(negedge clk);
        op_valid_i = 1'b1; op_code_i = 4'(op); word_i = w; dst_i = d; src_i = s;
        #1;
        check(rq, "result", int'(result_o), int'(er));
        if (!w && (op <= 12)) check("R8", "upper byte", int'(result_o[15:8]), int'(d[15:8]));
        check("R7", "wr_en", int'(wr_en_o), int'(ewr));
        check("R10", "wr_hi_en", int'(wr_hi_en_o), int'(ehw));
        check("R10", "result_hi", int'(result_hi_o), d[15] ? 32'hFFFF : 0);
        @(posedge clk);
        #1;
        check(rq, "flags", int'(flags_o), int'(ef));
        if (op <= 7) check("R9", "pf/af", int'({flags_o[2], flags_o[1]}), int'({ef[2], ef[1]}));
        mflags = ef;
    endtask

    function automatic logic [7:0] pick_src(input int j);
        case (j)
            0: return 8'h00;  1: return 8'h01;  2: return 8'h0F;  3: return 8'h7F;
            4: return 8'h80;  5: return 8'hFF;  6: return 8'h10;  7: return 8'hFE;
            default: return 8'((j * 37 + 5) & 255);
        endcase
    endfunction

    function automatic logic [15:0] pick_word(input int k, input logic [31:0] rnd);
        case (k % 16)
            0: return 16'h0000;  1: return 16'h0001;  2: return 16'h7FFF;
            3: return 16'h8000;  4: return 16'hFFFF;  5: return 16'h000F;
            default: return rnd[23:8];
        endcase
    endfunction

    initial begin
        logic [15:0] hold;
        repeat (3) @(posedge clk);
        #1;
        check("R11", "reset flags", int'(flags_o), 0);
        @(negedge clk);
        rst = 1'b0;

        // R8: byte-mode sweep over every destination byte, all opcodes
        for (int op = 0; op < 16; op++) begin
            for (int dv = 0; dv < 256; dv++) begin
                for (int j = 0; j < 16; j++) begin
                    seed = seed * 32'd1103515245 + 32'd12345;
                    run_op(op, 1'b0, {seed[23:16], 8'(dv)}, {seed[31:24], pick_src(j)});
                end
            end
        end

        // word-mode vectors with corner operands
        for (int op = 0; op < 16; op++) begin
            for (int k = 0; k < 800; k++) begin
                logic [15:0] dw, sw;
                seed = seed * 32'd1103515245 + 32'd12345;
                dw = pick_word(k, seed);
                seed = seed * 32'd1103515245 + 32'd12345;
                sw = pick_word(k / 16, seed);
                run_op(op, 1'b1, dw, sw);
            end
        end

        // R11: idle cycle with an add on the bus leaves the flags alone
        run_op(2, 1'b1, 16'h0000, 16'h0001);
        hold = {10'd0, flags_o};
        @(negedge clk);
        op_valid_i = 1'b0; op_code_i = 4'd0; word_i = 1'b1; dst_i = 16'h0000; src_i = 16'h0000;
        @(posedge clk);
        #1;
        check("R11", "idle hold", int'(flags_o), int'(hold));

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual running expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule